// File: doc/BRIEF.md
# Dual-Clock FIFO with Quadrant Direction Tracking

This block moves data words from one clock domain into another through a two-port storage array. The writing side has its own clock, enable and data input, and sees a full indication. The reading side has its own clock, enable and registered data output, and sees an empty indication. The two clocks are unrelated and run continuously; transfers are controlled only by the enables. Both address counters step through a Gray sequence, so an address seen from the other domain never changes in more than one bit at a time.

Full and empty are not told apart by extra wrap bits. A single equality compare between the two Gray addresses signals that the store is either completely full or completely empty. A direction latch settles which of the two it is. The latch watches which quarter of the address ring each counter is in. When the writer is one quarter behind the reader, it records "heading for full". When the writer is one quarter ahead, it records "heading for empty". The other quarter pairings leave it alone.

Each flag is raised at once by the port that causes it, because that port's own clock edge creates the equality. The release of a flag comes from the opposite port and is retimed through a two-stage synchronizer in the clock of the port that uses the flag. A flag can therefore linger for up to two cycles after the condition ends, but it is never shown clear while the condition still holds.

Top module: `async_fifo_qdir`

## Requirements
- R1: Words leave in the order they were accepted. A read accepted at a read-clock edge (rd_en high, rd_empty low) presents the oldest unread word on rd_data right after that edge, and every accepted access moves its own address pointer.
- R2: The FIFO holds exactly 2**ADDR_W words. After 2**ADDR_W - 1 unread writes wr_full is low, and after 2**ADDR_W unread writes it is high.
- R3: A write attempted while wr_full is high is dropped: the pointer does not move and the word is never read out.
- R4: A read attempted while rd_empty is high is dropped: the pointer does not move, rd_empty stays high, and the next word written is the next word read.
- R5: wr_full rises right after the write-clock edge that stores the last free entry, before the next write-clock edge.
- R6: rd_empty rises right after the read-clock edge that takes the last stored word, before the next read-clock edge.
- R7: After a read frees an entry of a full FIFO, wr_full stays high through the first write-clock edge that follows and is low after the second.
- R8: After a write into an empty FIFO, rd_empty stays high through the first read-clock edge that follows and is low after the second.
- R9: While either domain's reset is applied, and after it is released, the FIFO is empty: rd_empty high, wr_full low, both pointers at zero.
- R10: Each address pointer changes in at most one bit per clock of its own domain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock, free running |
| wr_rst_n | input | 1 | Write-domain reset, active low, asynchronous assert |
| wr_en | input | 1 | Request to store wr_data at this write-clock edge |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No free entry; writes are dropped |
| rd_clk | input | 1 | Read-domain clock, free running |
| rd_rst_n | input | 1 | Read-domain reset, active low, asynchronous assert |
| rd_en | input | 1 | Request to take the oldest word at this read-clock edge |
| rd_data | output | DATA_W | Registered oldest word, updated after an accepted read |
| rd_empty | output | 1 | Nothing stored; reads are dropped |

## Verification
On every cycle the assertions check several pointer properties. Each pointer holds while its own flag blocks the port, advances on every accepted access, and moves in at most one bit. A flag rises only after its own port has just made an access, and empty holds during reset. Only the bench scenarios can show the rest. These are the order and integrity of data across many wraps of the ring, the exact capacity, and the fact that a dropped write never surfaces. They also cover the two-edge release latency of each flag as seen from the other clock.

// File: rtl/async_fifo_qdir_pkg.sv
package async_fifo_qdir_pkg;

  // Quarter of the address ring, taken from the two top Gray bits.
  // Gray top pairs run 00,01,11,10 as the ring advances; this maps them to 0..3.
  function automatic logic [1:0] ring_quarter(input logic [1:0] gray_top);
    ring_quarter = {gray_top[1], gray_top[1] ^ gray_top[0]};
  endfunction

  function automatic logic [1:0] quarter_gap(input logic [1:0] from_q, input logic [1:0] to_q);
    quarter_gap = to_q - from_q;
  endfunction

  typedef enum logic {
    HEAD_EMPTY = 1'b0,
    HEAD_FULL  = 1'b1
  } heading_e;

endpackage

// File: rtl/qdir_rst_sync.sv
module qdir_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/qdir_gray_ptr.sv
module qdir_gray_ptr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr_gray
);
  logic [ADDR_W-1:0] bin_q, bin_d;
  logic [ADDR_W-1:0] gray_q, gray_d;

  always_comb begin
    bin_d  = bin_q + ADDR_W'(1);
    gray_d = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (step) begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  assign ptr_gray = gray_q;
endmodule

// File: rtl/qdir_dpram.sv
module qdir_dpram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)  rdata_q <= '0;
    else if (re)  rdata_q <= store[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/qdir_heading.sv
module qdir_heading
  import async_fifo_qdir_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              arst_n,
  input  logic [ADDR_W-1:0] wptr_gray,
  input  logic [ADDR_W-1:0] rptr_gray,
  output logic              full_term,
  output logic              empty_term
);
  logic [1:0] wq, rq;
  logic       toward_full, toward_empty;
  logic       ptr_match;
  heading_e   heading;

  always_comb begin
    wq           = ring_quarter(wptr_gray[ADDR_W-1 -: 2]);
    rq           = ring_quarter(rptr_gray[ADDR_W-1 -: 2]);
    toward_full  = (quarter_gap(wq, rq) == 2'd1);
    toward_empty = (quarter_gap(rq, wq) == 2'd1);
    ptr_match    = (wptr_gray == rptr_gray);
  end

  always_latch begin
    if (!arst_n)           heading <= HEAD_EMPTY;
    else if (toward_full)  heading <= HEAD_FULL;
    else if (toward_empty) heading <= HEAD_EMPTY;
  end

  assign full_term  = ptr_match && (heading == HEAD_FULL);
  assign empty_term = ptr_match && (heading == HEAD_EMPTY);
endmodule

// File: rtl/qdir_flag.sv
module qdir_flag #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  output logic flag
);
  logic [STAGES-1:0] hold_q;
  logic [STAGES-1:0] hold_d;

  always_comb begin
    hold_d = {hold_q[STAGES-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n or posedge raise) begin
    if (!rst_n)     hold_q <= {STAGES{RST_VAL}};
    else if (raise) hold_q <= '1;
    else            hold_q <= hold_d;
  end

  assign flag = hold_q[STAGES-1];
endmodule

// File: rtl/async_fifo_qdir.sv
module async_fifo_qdir #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty
);
  logic              wrst_n_s, rrst_n_s;
  logic              any_rst_n;
  logic              wr_take, rd_take;
  logic [ADDR_W-1:0] wptr_g, rptr_g;
  logic              full_term, empty_term;

  assign any_rst_n = wr_rst_n & rd_rst_n;
  assign wr_take   = wr_en & ~wr_full;
  assign rd_take   = rd_en & ~rd_empty;

  qdir_rst_sync #(.STAGES(SYNC_STAGES)) u_wrst (
    .clk(wr_clk), .arst_n(any_rst_n), .rst_n(wrst_n_s)
  );

  qdir_rst_sync #(.STAGES(SYNC_STAGES)) u_rrst (
    .clk(rd_clk), .arst_n(any_rst_n), .rst_n(rrst_n_s)
  );

  qdir_gray_ptr #(.ADDR_W(ADDR_W)) u_wptr (
    .clk(wr_clk), .rst_n(wrst_n_s), .step(wr_take), .ptr_gray(wptr_g)
  );

  qdir_gray_ptr #(.ADDR_W(ADDR_W)) u_rptr (
    .clk(rd_clk), .rst_n(rrst_n_s), .step(rd_take), .ptr_gray(rptr_g)
  );

  qdir_dpram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk(wr_clk), .we(wr_take), .waddr(wptr_g), .wdata(wr_data),
    .rclk(rd_clk), .rrst_n(rrst_n_s), .re(rd_take), .raddr(rptr_g),
    .rdata(rd_data)
  );

  qdir_heading #(.ADDR_W(ADDR_W)) u_head (
    .arst_n(any_rst_n), .wptr_gray(wptr_g), .rptr_gray(rptr_g),
    .full_term(full_term), .empty_term(empty_term)
  );

  qdir_flag #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_full (
    .clk(wr_clk), .rst_n(wrst_n_s), .raise(full_term), .flag(wr_full)
  );

  qdir_flag #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_empty (
    .clk(rd_clk), .rst_n(rrst_n_s), .raise(empty_term), .flag(rd_empty)
  );
endmodule

// File: rtl/async_fifo_qdir_chk.sv
module async_fifo_qdir_chk #(
  parameter int ADDR_W = 8
) (
  input logic              wr_clk,
  input logic              wrst_n,
  input logic              wr_en,
  input logic              wr_full,
  input logic [ADDR_W-1:0] wptr_g,
  input logic              rd_clk,
  input logic              rrst_n,
  input logic              rd_en,
  input logic              rd_empty,
  input logic [ADDR_W-1:0] rptr_g
);
  assert_wr_hold_full_R3: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    wr_full |=> $stable(wptr_g));

  assert_rd_hold_empty_R4: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    rd_empty |=> $stable(rptr_g));

  assert_wr_advance_R1: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    (wr_en && !wr_full) |=> (wptr_g != $past(wptr_g)));

  assert_rd_advance_R1: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    (rd_en && !rd_empty) |=> (rptr_g != $past(rptr_g)));

  assert_wr_gray_step_R10: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    $countones(wptr_g ^ $past(wptr_g)) <= 1);

  assert_rd_gray_step_R10: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    $countones(rptr_g ^ $past(rptr_g)) <= 1);

  assert_full_rise_by_write_R5: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    $rose(wr_full) |-> $past(wr_en));

  assert_empty_rise_by_read_R6: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    $rose(rd_empty) |-> $past(rd_en));

  assert_empty_in_reset_R9: assert property (@(posedge rd_clk)
    !rrst_n |-> rd_empty);
endmodule

bind async_fifo_qdir async_fifo_qdir_chk #(.ADDR_W(ADDR_W)) u_chk (
  .wr_clk(wr_clk), .wrst_n(wrst_n_s), .wr_en(wr_en), .wr_full(wr_full), .wptr_g(wptr_g),
  .rd_clk(rd_clk), .rrst_n(rrst_n_s), .rd_en(rd_en), .rd_empty(rd_empty), .rptr_g(rptr_g)
);

// File: tb/async_fifo_qdir_tb.sv
`timescale 1ns/1ps
module async_fifo_qdir_tb;
  localparam int DW    = 8;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          wr_clk = 1'b0, rd_clk = 1'b0;
  logic          wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          wr_full, rd_empty;

  always #4 wr_clk = ~wr_clk;                       // 125 MHz
  initial begin #1; forever #6.5 rd_clk = ~rd_clk; end

  async_fifo_qdir #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty)
  );

  int total = 0, bad = 0;
  logic [DW-1:0] sbq[$];
  bit  rd_on = 0;
  int  rd_pct = 100;
  int  rd_credit = 0;
  bit  pend = 0;
  int  pops = 0;
  bit  finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: issues reads and compares results against the scoreboard queue.
  initial begin
    forever begin
      @(negedge rd_clk);
      if (pend) begin
        if (sbq.size() == 0) chk(1'b0, "R1 read with empty scoreboard", int'(rd_data), -1);
        else begin
          logic [DW-1:0] exp_w;
          exp_w = sbq.pop_front();
          chk(rd_data == exp_w, "R1 data order", int'(rd_data), int'(exp_w));
        end
        pops++;
      end
      rd_en = (rd_on && ($urandom_range(99) < rd_pct)) || (rd_credit > 0);
      if (rd_credit > 0) rd_credit--;
      pend = rd_en && !rd_empty;
    end
  end

  // Driver: one write attempt; pushes the word if the port accepts it.
  task automatic wr_word(input logic [DW-1:0] d, output bit acc);
    @(negedge wr_clk);
    wr_en   = 1'b1;
    wr_data = d;
    acc     = !wr_full;
    @(posedge wr_clk);
    if (acc) sbq.push_back(d);
    wr_en <= 1'b0;
  endtask

  task automatic wr_until(input logic [DW-1:0] d);
    bit acc;
    acc = 0;
    while (!acc) wr_word(d, acc);
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit acc;
    int cnt;
    int base;

    // R9: reset state
    repeat (4) @(posedge wr_clk);
    @(negedge wr_clk);
    chk(rd_empty == 1'b1, "R9 empty in reset", rd_empty, 1);
    chk(wr_full == 1'b0, "R9 full in reset", wr_full, 0);
    wr_rst_n = 1'b1; rd_rst_n = 1'b1;
    repeat (6) @(posedge rd_clk);
    @(negedge rd_clk);
    chk(rd_empty == 1'b1, "R9 empty after reset", rd_empty, 1);
    chk(wr_full == 1'b0, "R9 full after reset", wr_full, 0);

    // R4: reads while empty are dropped
    rd_credit = 3;
    wait (rd_credit == 0);
    repeat (3) @(negedge rd_clk);
    chk(pops == 0, "R4 no data from empty", pops, 0);
    chk(rd_empty == 1'b1, "R4 empty kept", rd_empty, 1);
    wr_word(8'hA5, acc);
    repeat (4) @(negedge rd_clk);
    rd_credit = 1;
    wait (pops == 1);
    chk(sbq.size() == 0, "R4 next write is next read", sbq.size(), 0);
    chk(rd_empty == 1'b1, "R6 empty right after last read", rd_empty, 1);

    // R8: empty release latency after a write into an empty FIFO
    wr_word(8'h3C, acc);
    @(posedge rd_clk); @(negedge rd_clk);
    chk(rd_empty == 1'b1, "R8 empty held one read edge", rd_empty, 1);
    @(posedge rd_clk); @(negedge rd_clk);
    chk(rd_empty == 1'b0, "R8 empty released after two", rd_empty, 0);
    rd_credit = 1;
    wait (pops == 2);
    chk(rd_empty == 1'b1, "R6 empty right after drain", rd_empty, 1);

    // R2/R5: fill to capacity
    repeat (4) @(negedge wr_clk);
    cnt = 0;
    for (int i = 0; i < DEPTH; i++) begin
      wr_word(DW'(i ^ 8'h5A), acc);
      if (acc) cnt++;
      if (i == DEPTH - 2) begin
        @(negedge wr_clk);
        chk(wr_full == 1'b0, "R2 not full one short", wr_full, 0);
      end
    end
    @(negedge wr_clk);
    chk(wr_full == 1'b1, "R5 full right after last write", wr_full, 1);
    chk(cnt == DEPTH, "R2 accepted count", cnt, DEPTH);

    // R3: write while full is dropped
    wr_word(8'hEE, acc);
    chk(acc == 1'b0, "R3 write refused when full", acc, 0);
    @(negedge wr_clk);
    chk(wr_full == 1'b1, "R3 full kept", wr_full, 1);
    chk(sbq.size() == DEPTH, "R3 scoreboard depth", sbq.size(), DEPTH);

    // R7: full release latency
    rd_credit = 1;
    wait (pend);
    @(posedge rd_clk);
    @(posedge wr_clk); @(negedge wr_clk);
    chk(wr_full == 1'b1, "R7 full held one write edge", wr_full, 1);
    @(posedge wr_clk); @(negedge wr_clk);
    chk(wr_full == 1'b0, "R7 full released after two", wr_full, 0);
    wr_word(8'h77, acc);
    chk(acc == 1'b1, "R2 freed entry accepted", acc, 1);
    @(negedge wr_clk);
    chk(wr_full == 1'b1, "R5 full again", wr_full, 1);

    // drain: every stored word, none of them the dropped one (R3, R1)
    base = pops;
    rd_on = 1; rd_pct = 100;
    wait (sbq.size() == 0);
    repeat (4) @(negedge rd_clk);
    chk(pops - base == DEPTH, "R3 drained count", pops - base, DEPTH);
    chk(rd_empty == 1'b1, "R6 empty after drain", rd_empty, 1);

    // streaming with a mid-rate reader: many ring wraps (R1, R10)
    rd_pct = 60;
    for (int i = 0; i < 1200; i++) begin
      wr_until(DW'($urandom));
      if ($urandom_range(3) == 0) @(negedge wr_clk);
    end
    // slow reader: the FIFO hits full repeatedly (R2, R3)
    rd_pct = 15;
    for (int i = 0; i < 700; i++) wr_until(DW'(i * 7 + 1));
    rd_pct = 100;
    wait (sbq.size() == 0);
    repeat (4) @(negedge rd_clk);
    chk(rd_empty == 1'b1, "R1 empty after stream", rd_empty, 1);
    chk(wr_full == 1'b0, "R1 not full after stream", wr_full, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule